// File: doc/BRIEF.md
# Real-Time Clock Interrupt Enable and Flag Register Pair

This block holds the interrupt controls and the interrupt status of a real-time clock. A control register holds four enable bits: periodic, alarm, update-ended and square-wave output. A status register latches one flag for each of the three event sources. Each flag is set by a one-cycle pulse from elsewhere in the clock, whether or not its enable is on. The active-low interrupt output is asserted while any flag is set together with its own enable.

Software reaches both registers through a small single-cycle bus. A write to the control address loads the enables. A read of the status address returns the flags and a summary bit, then clears every flag. The block also watches the clock's time-setting bit: a rising edge on it clears the update-ended enable. The square-wave frequency comes from an external divider, and this block only gates it onto its output.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, all four enables and all three flags are cleared. After reset, the control read returns 0x00, the status read returns 0x00, irq_n is 1 and sqw_out is 0.
- R2: The control register sits at bus_addr 0. Its bit 0 is the periodic enable, bit 1 the alarm enable, bit 2 the update-ended enable and bit 3 the square-wave enable. A write is readable from the next cycle on, and bits 7:4 always read 0.
- R3: The status register sits at bus_addr 1. Its bit 0 is the periodic flag, bit 1 the alarm flag and bit 2 the update-ended flag; bits 6:3 read 0. A pulse on a source sets its flag at the next clock edge whatever its enable is, and the flag stays set until it is cleared.
- R4: irq_n is 0 exactly when at least one flag is set and its own enable is 1. A flag whose enable is 0 leaves irq_n at 1. Turning the enable on afterwards drives irq_n to 0.
- R5: Bit 7 of the status read is 1 exactly when irq_n is 0.
- R6: A status read returns the current flags and clears all of them at the end of that cycle. irq_n is 1 in the next cycle unless another flag/enable pair is still active.
- R7: A source pulse in the same cycle as a clearing status read leaves that flag set.
- R8: A 0-to-1 change of set_mode clears the update-ended enable, even if the same cycle writes a 1 into it. Holding set_mode at 1 does not clear a later write.
- R9: sqw_out equals sqw_src while the square-wave enable is 1, and is 0 while it is 0.
- R10: A write to bus_addr 1 changes neither the flags nor the enables.
- R11: A rising set_mode leaves the periodic, alarm and square-wave enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control register, 1 = status register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the access |
| tick_periodic | input | 1 | One-cycle pulse at the selected periodic rate |
| alarm_hit | input | 1 | One-cycle pulse on an alarm match |
| update_done | input | 1 | One-cycle pulse when a time update completes |
| set_mode | input | 1 | Time-setting bit level |
| sqw_src | input | 1 | Square wave from the rate divider |
| irq_n | output | 1 | Interrupt request, active low |
| sqw_out | output | 1 | Gated square wave |

## Verification
A flag register that is stuck or cleared too early shows at the ports at once. irq_n stays high one cycle after an enabled pulse, and the next status read returns the wrong bits. An enable bit held in the wrong state shows either as a wrong control readback in the next cycle or as irq_n following the wrong flag. The summary bit of the same read also shows it. A set-edge detector that fires on level instead of edge becomes visible as soon as software rewrites the update enable while set_mode stays high.

// File: rtl/rtc_irq_pkg.sv
// Package: shared widths, bit positions and addresses for the RTC
// interrupt enable/flag block. Assumes an 8-bit data bus.
package rtc_irq_pkg;
    localparam int DATA_W   = 8;
    localparam int NUM_SRC  = 3;               // periodic, alarm, update-ended
    localparam int EN_W     = NUM_SRC + 1;     // source enables plus square-wave enable
    localparam int SRC_PER  = 0;
    localparam int SRC_ALM  = 1;
    localparam int SRC_UPD  = 2;
    localparam int EN_SQW   = NUM_SRC;
    localparam int IRQF_BIT = DATA_W - 1;
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_FLAG = 1'b1;
    // Enables cleared by a rising edge of the time-setting bit.
    localparam logic [EN_W-1:0] SET_CLR_MASK = EN_W'(1) << SRC_UPD;
endpackage

// File: rtl/rtc_irq_bus.sv
// Module: rtc_irq_bus
// Decodes single-cycle bus accesses into a control-register write strobe
// and a status-read clear strobe, and builds the combinational read data.
// Assumes that a bus access lasts exactly one clock cycle.
module rtc_irq_bus
    import rtc_irq_pkg::*;
(
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [EN_W-1:0]   en_q,
    input  logic [NUM_SRC-1:0] flag_q,
    input  logic              irq_hit,
    output logic              ctrl_we,
    output logic              flag_rd,
    output logic [DATA_W-1:0] rdata
);
    // Write strobe for the control register.
    always_comb ctrl_we = bus_sel && bus_wr && (bus_addr == ADDR_CTRL);

    // Clearing read strobe for the status register.
    always_comb flag_rd = bus_sel && !bus_wr && (bus_addr == ADDR_FLAG);

    // Read multiplexer; unused bits read as zero.
    always_comb begin
        rdata = '0;
        if (bus_addr == ADDR_CTRL) begin
            rdata[EN_W-1:0] = en_q;
        end else begin
            rdata[NUM_SRC-1:0] = flag_q;
            rdata[IRQF_BIT]    = irq_hit;
        end
    end
endmodule

// File: rtl/rtc_irq_enables.sv
// Module: rtc_irq_enables
// Holds the enable bits. Reset clears every bit. A rising edge of the
// time-setting input clears the bits named in SET_CLR_MASK and takes
// priority over a write in the same cycle. Assumes set_mode is synchronous.
module rtc_irq_enables
    import rtc_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_mode,
    input  logic            we,
    input  logic [EN_W-1:0] wdata,
    output logic [EN_W-1:0] en_q
);
    logic set_prev;
    logic set_rise;

    // Remember the previous level of the time-setting bit.
    always_ff @(posedge clk) begin
        if (!rst_n) set_prev <= 1'b0;
        else        set_prev <= set_mode;
    end

    // Detect the 0-to-1 change of the time-setting bit.
    always_comb set_rise = set_mode && !set_prev;

    for (genvar i = 0; i < EN_W; i++) begin : g_en
        // One enable bit: reset, then set-edge clear, then bus write.
        always_ff @(posedge clk) begin
            if (!rst_n)                           en_q[i] <= 1'b0;
            else if (set_rise && SET_CLR_MASK[i]) en_q[i] <= 1'b0;
            else if (we)                          en_q[i] <= wdata[i];
        end

        if (SET_CLR_MASK[i]) begin : g_clr
            a_r8_set_rise_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (set_mode && !$past(set_mode)) |=> !en_q[i]);
        end else begin : g_keep
            a_r11_set_rise_keeps: assert property (@(posedge clk) disable iff (!rst_n)
                (set_mode && !$past(set_mode) && !we) |=> $stable(en_q[i]));
        end
    end

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !(set_mode && !$past(set_mode))) |=> (en_q == $past(wdata)));
endmodule

// File: rtl/rtc_irq_flags.sv
// Module: rtc_irq_flags
// Latches one sticky flag for each event source. A pulse sets its flag
// whatever the enables are. A clearing read drops all flags, except that
// a pulse arriving in the same cycle wins. Assumes pulses last one cycle.
module rtc_irq_flags
    import rtc_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               clr,
    output logic [NUM_SRC-1:0] flag_q
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
        // One sticky flag: an event beats the clear.
        always_ff @(posedge clk) begin
            if (!rst_n)      flag_q[i] <= 1'b0;
            else if (evt[i]) flag_q[i] <= 1'b1;
            else if (clr)    flag_q[i] <= 1'b0;
        end

        a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> flag_q[i]);
        a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !evt[i]) |=> !flag_q[i]);
        a_r7_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && evt[i]) |=> flag_q[i]);
        a_r3_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr) |=> flag_q[i]);
    end
endmodule

// File: rtl/rtc_irq_ctrl.sv
// Module: rtc_irq_ctrl (top)
// RTC interrupt enable/flag register pair. It combines flags with their
// enables into the active-low interrupt and gates the square wave.
// Assumes all inputs are synchronous to clk.
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_periodic,
    input  logic              alarm_hit,
    input  logic              update_done,
    input  logic              set_mode,
    input  logic              sqw_src,
    output logic              irq_n,
    output logic              sqw_out
);
    logic [EN_W-1:0]    en_q;
    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] evt;
    logic               ctrl_we;
    logic               flag_rd;
    logic               irq_hit;

    // Collect the event pulses into source order.
    always_comb begin
        evt          = '0;
        evt[SRC_PER] = tick_periodic;
        evt[SRC_ALM] = alarm_hit;
        evt[SRC_UPD] = update_done;
    end

    rtc_irq_bus u_bus (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .en_q    (en_q),
        .flag_q  (flag_q),
        .irq_hit (irq_hit),
        .ctrl_we (ctrl_we),
        .flag_rd (flag_rd),
        .rdata   (bus_rdata)
    );

    rtc_irq_enables u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_mode(set_mode),
        .we      (ctrl_we),
        .wdata   (bus_wdata[EN_W-1:0]),
        .en_q    (en_q)
    );

    rtc_irq_flags u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .clr   (flag_rd),
        .flag_q(flag_q)
    );

    // Any flag paired with its own enable requests an interrupt.
    always_comb irq_hit = |(flag_q & en_q[NUM_SRC-1:0]);

    // Drive the interrupt output low while a request is pending.
    always_comb irq_n = !irq_hit;

    // Pass the square wave only while it is enabled.
    always_comb sqw_out = sqw_src && en_q[EN_SQW];

    a_r4_no_flag_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q == '0) |-> irq_n);
    a_r4_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q[NUM_SRC-1:0] == '0) |-> irq_n);
    a_r9_sqw_held_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[EN_SQW] |-> !sqw_out);
    a_r5_summary_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_FLAG) |-> (bus_rdata[IRQF_BIT] == !irq_n));
    a_r10_flag_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_FLAG && evt == '0 && !set_mode)
            |=> ($stable(flag_q) && $stable(en_q)));
endmodule

// File: tb/rtc_irq_ctrl_tb_top.sv
module rtc_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tick_periodic = 1'b0, alarm_hit = 1'b0, update_done = 1'b0;
    logic       set_mode = 1'b0, sqw_src = 1'b0;
    logic       irq_n, sqw_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_periodic(tick_periodic), .alarm_hit(alarm_hit), .update_done(update_done),
        .set_mode(set_mode), .sqw_src(sqw_src),
        .irq_n(irq_n), .sqw_out(sqw_out)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(logic a, logic [7:0] v);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = v;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(logic a, output logic [7:0] v);
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk); bus_sel = 0;
    endtask

    task automatic pulse(int src);
        @(negedge clk);
        tick_periodic = (src == 0); alarm_hit = (src == 1); update_done = (src == 2);
        @(negedge clk);
        tick_periodic = 0; alarm_hit = 0; update_done = 0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        #1 chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
        chk("R1 sqw_out", {7'b0, sqw_out}, 8'h00);
        rd(1'b0, v); chk("R1 ctrl", v, 8'h00);
        rd(1'b1, v); chk("R1 flags", v, 8'h00);
    endtask

    task automatic t_ctrl_rw();
        logic [7:0] v;
        wr(1'b0, 8'hFF); rd(1'b0, v); chk("R2 upper bits zero", v, 8'h0F);
        wr(1'b0, 8'h05); rd(1'b0, v); chk("R2 readback", v, 8'h05);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_flag_no_enable();
        logic [7:0] v;
        pulse(0);
        #1 chk("R4 disabled flag irq_n", {7'b0, irq_n}, 8'h01);
        rd(1'b1, v); chk("R3 flag set without enable", v, 8'h01);
        rd(1'b1, v); chk("R6 flags cleared", v, 8'h00);
    endtask

    task automatic t_enable_after();
        logic [7:0] v;
        pulse(0);
        #1 chk("R4 before enable", {7'b0, irq_n}, 8'h01);
        wr(1'b0, 8'h01);
        #1 chk("R4 after enable", {7'b0, irq_n}, 8'h00);
        rd(1'b1, v); chk("R5 summary bit", v, 8'h81);
        #1 chk("R6 irq released", {7'b0, irq_n}, 8'h01);
    endtask

    task automatic t_alarm_update();
        logic [7:0] v;
        wr(1'b0, 8'h01); pulse(1);
        #1 chk("R4 alarm masked", {7'b0, irq_n}, 8'h01);
        rd(1'b1, v); chk("R5 no summary", v, 8'h02);
        wr(1'b0, 8'h02); pulse(1);
        #1 chk("R4 alarm irq", {7'b0, irq_n}, 8'h00);
        rd(1'b1, v); chk("R3 alarm flag", v, 8'h82);
        wr(1'b0, 8'h04); pulse(2);
        #1 chk("R4 update irq", {7'b0, irq_n}, 8'h00);
        rd(1'b1, v); chk("R3 update flag", v, 8'h84);
    endtask

    task automatic t_read_race();
        logic [7:0] v;
        wr(1'b0, 8'h01); pulse(0);
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = 1; tick_periodic = 1;
        #1 v = bus_rdata;
        @(negedge clk); bus_sel = 0; tick_periodic = 0;
        chk("R6 read value", v, 8'h81);
        #1 chk("R7 irq still low", {7'b0, irq_n}, 8'h00);
        rd(1'b1, v); chk("R7 flag kept", v, 8'h81);
    endtask

    task automatic t_set_edge();
        logic [7:0] v;
        set_mode = 0; wr(1'b0, 8'h0F);
        @(negedge clk); set_mode = 1;
        @(negedge clk);
        rd(1'b0, v); chk("R8 R11 set rise", v, 8'h0B);
        wr(1'b0, 8'h0F); rd(1'b0, v); chk("R8 level no clear", v, 8'h0F);
        @(negedge clk); set_mode = 0;
        @(negedge clk); set_mode = 1; bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 8'h04;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
        rd(1'b0, v); chk("R8 rise beats write", v, 8'h00);
        set_mode = 0;
    endtask

    task automatic t_sqw();
        wr(1'b0, 8'h00);
        @(negedge clk); sqw_src = 1; #1 chk("R9 held low", {7'b0, sqw_out}, 8'h00);
        wr(1'b0, 8'h08);
        @(negedge clk); sqw_src = 1; #1 chk("R9 follows high", {7'b0, sqw_out}, 8'h01);
        @(negedge clk); sqw_src = 0; #1 chk("R9 follows low", {7'b0, sqw_out}, 8'h00);
    endtask

    task automatic t_flag_write();
        logic [7:0] v;
        wr(1'b0, 8'h03); pulse(1);
        wr(1'b1, 8'h00);
        #1 chk("R10 irq unchanged", {7'b0, irq_n}, 8'h00);
        rd(1'b0, v); chk("R10 ctrl unchanged", v, 8'h03);
        rd(1'b1, v); chk("R10 flags unchanged", v, 8'h82);
    endtask

    task automatic t_reset_mid();
        logic [7:0] v;
        wr(1'b0, 8'h0F); pulse(0);
        do_reset();
        #1 chk("R1 irq after reset", {7'b0, irq_n}, 8'h01);
        rd(1'b0, v); chk("R1 ctrl after reset", v, 8'h00);
        rd(1'b1, v); chk("R1 flags after reset", v, 8'h00);
    endtask

    initial begin
        t_reset();
        t_ctrl_rw();
        t_flag_no_enable();
        t_enable_after();
        t_alarm_update();
        t_read_race();
        t_set_edge();
        t_sqw();
        t_flag_write();
        t_reset_mid();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule